// File: doc/BRIEF.md
# Start-Vector-Gated Receive Clock

This block sits behind a data slicer and turns a raw serial bitstream into a clocked bit interface for a host. A phase counter running at sixteen ticks per bit realigns itself on every transition of the incoming line and samples each bit near its centre. The recovered bits pass through a 16-bit shift register. Nothing reaches the host until the most recent sixteen bits, oldest first, read 0xE2E2.

After that match, the host clock output produces one pulse per bit period. Each pulse carries the next recovered bit on the data output. The clock keeps running even when the line stops toggling, and only a low level on the arm input silences it. Raising arm again starts a fresh search.

A rate input picks one of two bit rates. The per-rate tick dividers are derived from the system clock frequency given as a parameter. The rate in use is frozen while the output clock is live.

Top module: `svr_rx_gate`

## Requirements
- R1: Bits are pushed into the matcher oldest first (most significant first). The block locks only when the last sixteen recovered bits equal exactly 0xE2E2. A stream differing in any bit, such as 0xE2E3 followed by 0x62E2, never locks.
- R2: From reset until a lock, `rx_clk_o` and `rx_dat_o` both stay at 0.
- R3: After a lock, every recovered bit following the start vector produces exactly one rising edge of `rx_clk_o`. At that edge `rx_dat_o` shows the bit, and bits appear in line order.
- R4: Each `rx_clk_o` pulse is high for half a bit period (OVS/2 ticks). `rx_dat_o` changes only together with a rising edge of `rx_clk_o` (or when disarmed) and holds for the whole high phase.
- R5: Once locked, pulses continue once per bit period even if the line holds a constant level, until the block is disarmed.
- R6: With `arm_en_i` low, both outputs are 0 on the next cycle and the lock and match history are cleared. A start vector sent while `arm_en_i` is low is ignored. After `arm_en_i` returns high, no pulse appears until a new complete start vector arrives.
- R7: `rate_slow_i` = 1 selects SLOW_BPS and 0 selects FAST_BPS. The pulse period is OVS × floor(SYS_CLK_HZ / (rate × OVS)) system clocks.
- R8: A change of `rate_slow_i` while locked leaves the pulse period unchanged. The new rate applies from the next arming.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| rx_bit_i | input | 1 | Sliced serial receive line (asynchronous) |
| arm_en_i | input | 1 | Recognition enable; low clears, high searches |
| rate_slow_i | input | 1 | 1 = slow rate, 0 = fast rate |
| rx_clk_o | output | 1 | Gated recovered bit clock for the host |
| rx_dat_o | output | 1 | Recovered bit, updated at rising edges of rx_clk_o |

## Verification
Several patterns are run through the matcher, each testing a different part of its behaviour:
- An alternating preamble followed by the exact vector shows the match works with most-significant-first ordering.
- A near-miss stream (0xE2E3 then 0x62E2) shows the comparison uses all sixteen bits and does not match on shifted partial copies.
- A correct vector sent while disarmed, then idle traffic, shows the history is cleared rather than kept.

Several payload patterns test the output side:
- Transition-rich payloads check bit order and the realignment of the phase counter.
- An all-zero payload has no edges at all, so only free-running timing can produce its pulses.
- Flipping the rate input in the middle of a payload separates "rate frozen while locked" from "rate followed live", because the two give different pulse periods.

// File: rtl/svr_pkg.sv
package svr_pkg;

   typedef enum logic {
      RATE_FAST = 1'b0,
      RATE_SLOW = 1'b1
   } rate_e;

   function automatic int tick_div(input int clk_hz, input int bps, input int ovs);
      return clk_hz / (bps * ovs);
   endfunction

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/svr_tick_gen.sv
module svr_tick_gen
   import svr_pkg::*;
#(
   parameter int FAST_DIV = 4,
   parameter int SLOW_DIV = 16
)(
   input  logic  clk_i,
   input  logic  rst_i,
   input  rate_e rate_i,
   output logic  tick_o
);
   localparam int MAX_DIV = imax(FAST_DIV, SLOW_DIV);
   localparam int CNT_W   = (MAX_DIV > 1) ? $clog2(MAX_DIV) : 1;

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] reload;

   assign reload = (rate_i == RATE_SLOW) ? CNT_W'(SLOW_DIV - 1) : CNT_W'(FAST_DIV - 1);

   always_ff @(posedge clk_i) begin
      if (rst_i)
         cnt_q <= '0;
      else if (cnt_q == '0)
         cnt_q <= reload;
      else
         cnt_q <= cnt_q - 1'b1;
   end

   assign tick_o = (cnt_q == '0);

endmodule

// File: rtl/svr_bit_sync.sv
module svr_bit_sync #(
   parameter int OVS         = 16,
   parameter int SYNC_STAGES = 2
)(
   input  logic clk_i,
   input  logic rst_i,
   input  logic tick_i,
   input  logic rx_i,
   output logic stb_o,
   output logic val_o
);
   localparam int PH_W = $clog2(OVS);
   localparam int HALF = OVS / 2;

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   line_d;
   logic                   prev_q;
   logic [PH_W-1:0]        phase_q;
   logic [PH_W-1:0]        phase_nx;

   assign line_d   = sync_q[SYNC_STAGES-1];
   // any transition pulls the phase back to the bit boundary
   assign phase_nx = (line_d != prev_q) ? '0 : phase_q + 1'b1;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         sync_q  <= '0;
         prev_q  <= 1'b0;
         phase_q <= '0;
         stb_o   <= 1'b0;
         val_o   <= 1'b0;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], rx_i};
         stb_o  <= 1'b0;
         if (tick_i) begin
            prev_q  <= line_d;
            phase_q <= phase_nx;
            stb_o   <= (phase_nx == PH_W'(HALF));
            val_o   <= line_d;
         end
      end
   end

endmodule

// File: rtl/svr_vec_match.sv
module svr_vec_match #(
   parameter int               VEC_W     = 16,
   parameter logic [VEC_W-1:0] START_VEC = 16'hE2E2
)(
   input  logic clk_i,
   input  logic rst_i,
   input  logic en_i,
   input  logic stb_i,
   input  logic val_i,
   output logic locked_o,
   output logic data_stb_o,
   output logic data_val_o
);
   logic [VEC_W-1:0] hist_q;
   logic [VEC_W-1:0] hist_nx;

   assign hist_nx = {hist_q[VEC_W-2:0], val_i};

   always_ff @(posedge clk_i) begin
      if (rst_i || !en_i) begin
         hist_q   <= '0;
         locked_o <= 1'b0;
      end else if (stb_i) begin
         hist_q <= hist_nx;
         if (hist_nx == START_VEC)
            locked_o <= 1'b1;
      end
   end

   // the strobe that completes the match is not forwarded
   assign data_stb_o = stb_i && locked_o && en_i;
   assign data_val_o = val_i;

endmodule

// File: rtl/svr_rx_gate.sv
module svr_rx_gate
   import svr_pkg::*;
#(
   parameter int               SYS_CLK_HZ  = 200_000_000,
   parameter int               FAST_BPS    = 19_200,
   parameter int               SLOW_BPS    = 4_800,
   parameter int               OVS         = 16,
   parameter int               SYNC_STAGES = 2,
   parameter int               VEC_W       = 16,
   parameter logic [VEC_W-1:0] START_VEC   = 16'hE2E2
)(
   input  logic clk_i,
   input  logic rst_i,
   input  logic rx_bit_i,
   input  logic arm_en_i,
   input  logic rate_slow_i,
   output logic rx_clk_o,
   output logic rx_dat_o
);
   localparam int FAST_DIV   = tick_div(SYS_CLK_HZ, FAST_BPS, OVS);
   localparam int SLOW_DIV   = tick_div(SYS_CLK_HZ, SLOW_BPS, OVS);
   localparam int HALF       = OVS / 2;
   localparam int PH_W       = $clog2(OVS);
   localparam int HI_MAX_CYC = HALF * imax(FAST_DIV, SLOW_DIV) + 2;

   generate
      if (FAST_DIV < 1 || SLOW_DIV < 1) begin : g_bad_div
         $error("system clock too slow for the requested bit rates");
      end
      if (OVS < 4 || (OVS & (OVS - 1)) != 0) begin : g_bad_ovs
         $error("OVS must be a power of two of at least 4");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (VEC_W < 2) begin : g_bad_vec
         $error("VEC_W must be at least 2");
      end
   endgenerate

   rate_e           rate_q;
   logic            tick;
   logic            bit_stb;
   logic            bit_val;
   logic            vec_locked;
   logic            data_stb;
   logic            data_val;
   logic [PH_W-1:0] hi_cnt_q;

   // rate follows the input only while no clock is being emitted
   always_ff @(posedge clk_i) begin
      if (rst_i)
         rate_q <= RATE_FAST;
      else if (!vec_locked)
         rate_q <= rate_e'(rate_slow_i);
   end

   svr_tick_gen #(
      .FAST_DIV (FAST_DIV),
      .SLOW_DIV (SLOW_DIV)
   ) u_tick (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .rate_i (rate_q),
      .tick_o (tick)
   );

   svr_bit_sync #(
      .OVS         (OVS),
      .SYNC_STAGES (SYNC_STAGES)
   ) u_sync (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .tick_i (tick),
      .rx_i   (rx_bit_i),
      .stb_o  (bit_stb),
      .val_o  (bit_val)
   );

   svr_vec_match #(
      .VEC_W     (VEC_W),
      .START_VEC (START_VEC)
   ) u_match (
      .clk_i      (clk_i),
      .rst_i      (rst_i),
      .en_i       (arm_en_i),
      .stb_i      (bit_stb),
      .val_i      (bit_val),
      .locked_o   (vec_locked),
      .data_stb_o (data_stb),
      .data_val_o (data_val)
   );

   always_ff @(posedge clk_i) begin
      if (rst_i || !arm_en_i) begin
         rx_clk_o <= 1'b0;
         rx_dat_o <= 1'b0;
         hi_cnt_q <= '0;
      end else if (data_stb) begin
         rx_clk_o <= 1'b1;
         rx_dat_o <= data_val;
         hi_cnt_q <= '0;
      end else if (rx_clk_o && tick) begin
         if (hi_cnt_q == PH_W'(HALF - 1))
            rx_clk_o <= 1'b0;
         hi_cnt_q <= hi_cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/svr_rx_gate_chk.sv
module svr_rx_gate_chk #(
   parameter int HI_MAX = 1000
)(
   input logic clk_i,
   input logic rst_i,
   input logic arm_en_i,
   input logic rx_clk_o,
   input logic rx_dat_o,
   input logic lock_i
);
   logic [31:0] hi_len_q;

   always_ff @(posedge clk_i) begin
      if (rst_i || !rx_clk_o)
         hi_len_q <= '0;
      else
         hi_len_q <= hi_len_q + 1'b1;
   end

   // R2
   rise_needs_lock_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      $rose(rx_clk_o) |-> lock_i);

   // R6
   disarm_quiet_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      !$past(arm_en_i) |-> (!rx_clk_o && !rx_dat_o));

   // R6
   rearm_no_clock_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      $rose(arm_en_i) |=> !rx_clk_o);

   // R4
   data_hold_high_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (rx_clk_o && $past(rx_clk_o)) |-> $stable(rx_dat_o));

   // R4
   data_moves_on_rise_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      !$stable(rx_dat_o) |-> ($rose(rx_clk_o) || !rx_clk_o));

   // R4
   high_width_bound_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      hi_len_q <= HI_MAX);

endmodule

bind svr_rx_gate svr_rx_gate_chk #(
   .HI_MAX (HI_MAX_CYC)
) u_chk (
   .clk_i    (clk_i),
   .rst_i    (rst_i),
   .arm_en_i (arm_en_i),
   .rx_clk_o (rx_clk_o),
   .rx_dat_o (rx_dat_o),
   .lock_i   (vec_locked)
);

// File: tb/svr_rx_gate_bench.sv
`timescale 1ns/1ps
module svr_rx_gate_bench;
   localparam int SYS_HZ   = 1_228_800;
   localparam int FAST_BIT = 64;
   localparam int SLOW_BIT = 256;

   logic clk = 1'b0;
   logic rst, rx, en, rate, dclk, dat;

   always #2.5 clk = ~clk;

   svr_rx_gate #(
      .SYS_CLK_HZ (SYS_HZ),
      .FAST_BPS   (19_200),
      .SLOW_BPS   (4_800)
   ) u_svr_rx_gate (
      .clk_i       (clk),
      .rst_i       (rst),
      .rx_bit_i    (rx),
      .arm_en_i    (en),
      .rate_slow_i (rate),
      .rx_clk_o    (dclk),
      .rx_dat_o    (dat)
   );

   int    n_chk = 0, n_bad = 0, cyc = 0;
   bit    q[$];
   bit    armed_exp = 1'b0;
   int    exp_bit_cyc = FAST_BIT;
   string per_tag = "R7";
   int    last_rise = -1, rise_at = 0, rise_cnt = 0, hi = 0;
   logic  prev_clk = 1'b0, dat_at_rise = 1'b0;
   bit    exp_b;

   always @(posedge clk) cyc++;

   task automatic check(input bit ok, input string tag, input string what,
                        input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   // monitor: pops one expected bit per rising edge of the host clock
   always @(negedge clk) begin
      if (!rst) begin
         if (dclk && !prev_clk) begin
            rise_cnt++;
            if (!armed_exp)
               check(1'b0, "R2", "pulse before start vector", 1, 0);
            else if (q.size() == 0)
               check(1'b0, "R3", "pulse with no bit expected", 1, 0);
            else begin
               exp_b = q.pop_front();
               check(dat == exp_b, "R3", "bit at rising edge", int'(dat), int'(exp_b));
               if (last_rise >= 0)
                  check(cyc - last_rise == exp_bit_cyc, per_tag, "pulse period",
                        cyc - last_rise, exp_bit_cyc);
               last_rise = cyc;
            end
            dat_at_rise = dat;
            rise_at = cyc;
         end
         if (!dclk && prev_clk && armed_exp) begin
            hi = cyc - rise_at;
            check(dat == dat_at_rise, "R4", "data held over high phase",
                  int'(dat), int'(dat_at_rise));
            check(hi >= exp_bit_cyc/2 - 2 && hi <= exp_bit_cyc/2 + 1, "R4",
                  "high phase length", hi, exp_bit_cyc/2);
         end
         prev_clk = dclk;
      end
   end

   task automatic send_word(input logic [15:0] w, input int bc);
      for (int i = 15; i >= 0; i--) begin
         rx = w[i];
         repeat (bc) @(negedge clk);
      end
   endtask

   // driver: arm, send preamble + vector, push payload into scoreboard
   task automatic run_stream(input bit slow, input logic [15:0] data, input bit flip);
      int bc;
      bc = slow ? SLOW_BIT : FAST_BIT;
      @(negedge clk);
      en = 1'b0;
      rate = slow;
      repeat (3) @(negedge clk);
      en = 1'b1;
      repeat (3) @(negedge clk);
      send_word(16'hAAAA, bc);
      send_word(16'hE2E2, bc);
      for (int i = 15; i >= 0; i--) q.push_back(data[i]);
      exp_bit_cyc = bc;
      per_tag = flip ? "R8" : "R7";
      last_rise = -1;
      armed_exp = 1'b1;
      for (int i = 15; i >= 0; i--) begin
         rx = data[i];
         if (flip && i == 8) rate = ~slow;
         repeat ((i == 0) ? (bc * 5) / 4 : bc) @(negedge clk);
      end
      check(q.size() == 0, "R3", "payload bits not delivered", q.size(), 0);
      armed_exp = 1'b0;
      en = 1'b0;
      repeat (2) @(negedge clk);
      check(dclk == 1'b0 && dat == 1'b0, "R6", "outputs after disarm",
            int'({dclk, dat}), 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL R3 watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      int r0;
      rst = 1'b1; rx = 1'b0; en = 1'b0; rate = 1'b0;
      repeat (5) @(posedge clk);
      @(negedge clk) rst = 1'b0;
      @(negedge clk);
      // R2: reset state
      check(dclk == 1'b0, "R2", "clock after reset", int'(dclk), 0);
      check(dat == 1'b0, "R2", "data after reset", int'(dat), 0);

      // R1: near-miss stream must not lock
      en = 1'b1;
      repeat (4) @(negedge clk);
      r0 = rise_cnt;
      send_word(16'hAAAA, FAST_BIT);
      send_word(16'hE2E3, FAST_BIT);
      send_word(16'h62E2, FAST_BIT);
      repeat (2 * FAST_BIT) @(negedge clk);
      check(rise_cnt == r0, "R1", "pulses after near-miss", rise_cnt - r0, 0);
      check(dclk == 1'b0, "R1", "clock after near-miss", int'(dclk), 0);

      // R6: vector while disarmed is forgotten
      en = 1'b0;
      r0 = rise_cnt;
      send_word(16'hAAAA, FAST_BIT);
      send_word(16'hE2E2, FAST_BIT);
      en = 1'b1;
      send_word(16'h0000, FAST_BIT);
      check(rise_cnt == r0, "R6", "pulses after disarmed vector", rise_cnt - r0, 0);

      // R3 / R8: fast lock, rate flipped mid-payload
      run_stream(1'b0, 16'hC35A, 1'b1);

      // R6: re-armed (now slow) with no vector stays silent
      en = 1'b1;
      r0 = rise_cnt;
      send_word(16'h1234, SLOW_BIT);
      send_word(16'h0F0F, SLOW_BIT);
      check(rise_cnt == r0, "R6", "pulses after re-arm without vector", rise_cnt - r0, 0);

      // R5 / R7: slow lock, constant-zero payload relies on free running
      run_stream(1'b1, 16'h0000, 1'b0);

      // R7: fast lock, mixed payload
      run_stream(1'b0, 16'h5A0F, 1'b0);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule